// File: doc/BRIEF.md
# Segmented Address Relocation Unit

This block turns a 16-bit virtual address into a 16-bit physical address through a small table of segment descriptors. The top four bits of the virtual address pick one of sixteen descriptors. The low twelve bits are an offset that is added to that descriptor's base. Each descriptor carries a base, an exclusive upper limit, a present flag and a flag that marks the segment as code or data.

Supervisor software fills the table through a write port before it hands control to a process. Instruction fetches and operand accesses both pass through the same lookup, add and bounds check. The result is registered, so it appears one cycle after the request. It is either a physical address or a fault code: a protection fault or an absent-segment fault. A faulting access never forwards an address.

Top module: `seg_reloc`

## Requirements
- R1: The segment index is `req_vaddr[15:12]` and the offset is `req_vaddr[11:0]`. A legal access returns base + offset; for example, base 0x2020 and virtual address 0x12F0 give 0x2310.
- R2: An access is legal only when base + offset is strictly below the descriptor's limit. Otherwise `rsp_fault` is 1 (protection) and `rsp_paddr` is 0.
- R3: If base + offset carries out of 16 bits, the access is a protection fault (code 1), even when the wrapped low 16 bits are below the limit.
- R4: A reference to a segment whose present flag is 0 gives fault code 2 and `rsp_paddr` 0. This takes priority over every protection condition.
- R5: An instruction fetch (`req_fetch`=1) to a segment whose code flag is 0 is a protection fault (code 1). Operand accesses (`req_fetch`=0) are allowed to both code and data segments.
- R6: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. While `rsp_valid` is low, `rsp_paddr` and `rsp_fault` are 0.
- R7: After reset, `rsp_valid` is 0 and every descriptor is absent, so every access returns fault code 2 until the table is written.
- R8: A write with `cfg_we`=1 replaces descriptor `cfg_seg` at the clock edge. A request in the same cycle still sees the old descriptor; requests in later cycles see the new one.
- R9: The fault code is 0 for none, 1 for protection and 2 for an absent segment. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_seg | input | 4 | Index of the descriptor to write |
| cfg_base | input | 16 | New base |
| cfg_limit | input | 16 | New exclusive upper bound |
| cfg_present | input | 1 | New present flag |
| cfg_code | input | 1 | New code flag (1 = code, 0 = data) |
| req_valid | input | 1 | Translation request strobe |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| req_vaddr | input | 16 | Virtual address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | Fault code: 0 none, 1 protection, 2 absent |

## Verification
A corrupted descriptor shows up at the outputs on the first access to that segment, one cycle after the request. It appears as a wrong relocated address, or as a fault where none belongs (or the reverse). A present bit stuck after reset shows up the same way, as a missing code 2 before any configuration. The stimulus is built around exact bounds: an offset that lands on limit − 1 and on the limit itself, sums that reach 0xFFFF, and sums that carry out of 16 bits. A write in the same cycle as a request to that segment shows whether the update is applied at the right edge.

// File: rtl/seg_reloc.sv
module seg_reloc #(
  parameter int VA_W  = 16,
  parameter int SEG_W = 4,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_seg,
  input  logic [PA_W-1:0]  cfg_base,
  input  logic [PA_W-1:0]  cfg_limit,
  input  logic             cfg_present,
  input  logic             cfg_code,
  input  logic             req_valid,
  input  logic             req_fetch,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault
);
  localparam int OFF_W = VA_W - SEG_W;
  localparam int NSEG  = 1 << SEG_W;
  localparam logic [1:0] F_NONE   = 2'd0;
  localparam logic [1:0] F_PROT   = 2'd1;
  localparam logic [1:0] F_ABSENT = 2'd2;

  logic [PA_W-1:0] base_q  [NSEG];
  logic [PA_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0] pres_q;
  logic [NSEG-1:0] code_q;

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [PA_W:0]    sum;
  logic             sel_present;
  logic             prot;
  logic [1:0]       fault_d;

  assign seg         = req_vaddr[VA_W-1 -: SEG_W];
  assign off         = req_vaddr[OFF_W-1:0];
  assign sum         = {1'b0, base_q[seg]} + {{(PA_W+1-OFF_W){1'b0}}, off};
  assign sel_present = pres_q[seg];
  assign prot        = sum[PA_W] | (sum[PA_W-1:0] >= limit_q[seg]) | (req_fetch & ~code_q[seg]);
  assign fault_d     = !sel_present ? F_ABSENT : (prot ? F_PROT : F_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= '0;
      code_q <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
      end
    end else if (cfg_we) begin
      base_q[cfg_seg]  <= cfg_base;
      limit_q[cfg_seg] <= cfg_limit;
      pres_q[cfg_seg]  <= cfg_present;
      code_q[cfg_seg]  <= cfg_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= F_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault_d : F_NONE;
      rsp_paddr <= (req_valid && fault_d == F_NONE) ? sum[PA_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk #(
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            sel_present,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault
);
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 2'd0 && rsp_paddr == '0));

  p_absent_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_present) |=> (rsp_fault == 2'd2));

  p_no_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  p_fault_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'd3);
endmodule

bind seg_reloc seg_reloc_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .sel_present(sel_present),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/tb_seg_reloc.sv
`timescale 1ns/1ps
module tb_seg_reloc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_seg = 0;
  logic [15:0] cfg_base = 0;
  logic [15:0] cfg_limit = 0;
  logic        cfg_present = 0;
  logic        cfg_code = 0;
  logic        req_valid = 0;
  logic        req_fetch = 0;
  logic [15:0] req_vaddr = 0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int failures = 0;
  bit armed = 0;
  bit done = 0;

  logic [15:0] m_base [16];
  logic [15:0] m_limit[16];
  logic        m_pres [16];
  logic        m_code [16];

  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  seg_reloc dut (.*);

  function automatic logic [17:0] model(input logic f, input logic [15:0] va);
    logic [3:0]  s;
    logic [16:0] sm;
    s  = va[15:12];
    sm = {1'b0, m_base[s]} + {5'b0, va[11:0]};
    if (!m_pres[s]) return {2'd2, 16'h0};
    if (sm[16] || sm[15:0] >= m_limit[s] || (f && !m_code[s])) return {2'd1, 16'h0};
    return {2'd0, sm[15:0]};
  endfunction

  task automatic send(input logic f, input logic [15:0] va, input string tag);
    @(negedge clk);
    cfg_we = 0;
    req_valid = 1; req_fetch = f; req_vaddr = va;
    exp_q.push_back(model(f, va));
    tag_q.push_back(tag);
  endtask

  task automatic setd(input logic [3:0] s, input logic [15:0] b, input logic [15:0] l,
                      input logic p, input logic c);
    @(negedge clk);
    req_valid = 0;
    cfg_we = 1; cfg_seg = s; cfg_base = b; cfg_limit = l; cfg_present = p; cfg_code = c;
    m_base[s] = b; m_limit[s] = l; m_pres[s] = p; m_code[s] = c;
  endtask

  task automatic set_and_send(input logic [3:0] s, input logic [15:0] b, input logic [15:0] l,
                              input logic p, input logic c, input logic f, input logic [15:0] va,
                              input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_seg = s; cfg_base = b; cfg_limit = l; cfg_present = p; cfg_code = c;
    req_valid = 1; req_fetch = f; req_vaddr = va;
    exp_q.push_back(model(f, va));
    tag_q.push_back(tag);
    m_base[s] = b; m_limit[s] = l; m_pres[s] = p; m_code[s] = c;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cfg_we = 0; req_valid = 0;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (armed) begin
        checks++;
        if (rsp_valid) begin
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R6 unexpected response act=%0d/%h exp=none", rsp_fault, rsp_paddr);
          end else begin
            logic [17:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({rsp_fault, rsp_paddr} !== e) begin
              failures++;
              $display("FAIL %s act fault=%0d paddr=%h exp fault=%0d paddr=%h",
                       t, rsp_fault, rsp_paddr, e[17:16], e[15:0]);
            end
          end
        end else if (exp_q.size() != 0) begin
          failures++;
          void'(tag_q.pop_front());
          $display("FAIL R6 missing response act valid=0 exp valid=1 (%h)", exp_q.pop_front());
        end else if (rsp_fault !== 2'd0 || rsp_paddr !== 16'h0) begin
          failures++;
          $display("FAIL R6 idle outputs act=%0d/%h exp=0/0000", rsp_fault, rsp_paddr);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_base[i] = 0; m_limit[i] = 0; m_pres[i] = 0; m_code[i] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 2'd0 || rsp_paddr !== 16'h0) begin
      failures++;
      $display("FAIL R7 reset outputs act=%b/%0d/%h exp=0/0/0000", rsp_valid, rsp_fault, rsp_paddr);
    end
    rst_n = 1;
    @(negedge clk);
    armed = 1;

    // R7: empty table faults everywhere
    for (int s = 0; s < 16; s++) send(s[0], {s[3:0], 12'h123}, "R7 unconfigured");
    idle(2);

    // R1: relocation example
    setd(4'd1, 16'h2020, 16'h3000, 1, 1);
    send(0, 16'h12F0, "R1 relocation 0x12F0");
    send(1, 16'h1000, "R1 fetch offset 0");
    send(0, 16'h1FDF, "R1 last legal");
    send(0, 16'h1FE0, "R2 sum equals limit");

    // R2: limit boundary
    setd(4'd2, 16'h4000, 16'h4100, 1, 0);
    send(0, 16'h20FF, "R2 limit-1");
    send(0, 16'h2100, "R2 at limit");
    send(0, 16'h2FFF, "R2 above limit");

    // R3: carry out
    setd(4'd3, 16'hF800, 16'hFFFF, 1, 1);
    send(0, 16'h37FE, "R3 top legal");
    send(0, 16'h37FF, "R2 0xFFFF equals limit");
    send(0, 16'h3800, "R3 carry to zero");
    send(0, 16'h3900, "R3 carry wrapped below limit");

    // R4: absent wins over protection
    setd(4'd4, 16'hFF00, 16'h0010, 0, 0);
    send(1, 16'h4FFF, "R4 absent priority");
    send(0, 16'h4000, "R4 absent");

    // R5: code/data tag
    setd(4'd5, 16'h8000, 16'h9000, 1, 0);
    send(1, 16'h5010, "R5 fetch from data");
    send(0, 16'h5010, "R5 operand to data");
    send(0, 16'h1100, "R5 operand to code");
    idle(3);

    // R8: same-cycle write sees old contents
    set_and_send(4'd6, 16'h0100, 16'h0200, 1, 1, 0, 16'h6010, "R8 same-cycle old entry");
    send(0, 16'h6010, "R8 new entry visible");
    set_and_send(4'd1, 16'h7000, 16'h7800, 1, 1, 0, 16'h1010, "R8 old base in write cycle");
    send(0, 16'h1010, "R8 new base");
    send(1, 16'h17FF, "R8 new limit");

    // R6: mixed stream with gaps
    for (int k = 0; k < 40; k++) begin
      send(k[1], {k[2:0], k[4:0], 7'h15}, "R9 mixed stream");
      if (k % 7 == 3) idle(1);
    end
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule